// File: doc/BRIEF.md
# Dual-Wiper Register Bank with Non-Volatile Shadow

This block is the register core behind the serial port of a two-channel digital potentiometer. A serial front end turns bus traffic into single-cycle read and write strobes with a register address and a data byte. The bank holds two live 8-bit wiper codes, a small non-volatile store modelled as a register array, and a control byte. It drives the wiper codes, a shutdown request for the analog switches, and a flag that is high while a non-volatile write is in progress.

Addresses 0x00 and 0x01 each hold two registers, one per channel: a stored start-up value and the live wiper. A mode bit in the control byte picks which of the two a bus access reaches. A stored-value write also moves the live wiper. Writes to the store start a busy window whose length is a parameter (a cycle count that stands in for the 20 ms cell programming time). During that window wiper and control writes are dropped. A recall pulse copies both stored values into the live wipers and returns the control byte to its default. The `ready` output is held low until that copy is done.

The control state machine has four states. ST_BOOT waits after reset for the first recall. ST_LOAD_A copies the stored value into wiper A. ST_LOAD_B copies the stored value into wiper B. ST_RUN serves accesses. The transitions are:
- boot_to_load: `por_recall` in ST_BOOT.
- load_a_to_load_b: unconditional.
- load_b_to_run: unconditional.
- run_to_load: `por_recall` in ST_RUN.

A `por_recall` in ST_LOAD_A or ST_LOAD_B restarts at ST_LOAD_A.

Top module: `dpot_regbank`

## Requirements
- R1: After reset, `ready`=0, both wiper outputs and both stored values are 0x80, `shutdown`=0, `nv_busy`=0, and the control byte at 0x10 reads 0x40.
- R2: A `por_recall` pulse drops `ready` on the next cycle. Then wiper A is loaded from stored value 0x00 and wiper B from stored value 0x01, one per cycle. The control byte returns to 0x40 and `ready` rises two cycles after the pulse was taken.
- R3: With control bit 7 (volatile-only mode) at 0, an access to 0x00 or 0x01 reaches the stored value of channel A or B. A write there also sets the matching wiper output.
- R4: With control bit 7 at 1, an access to 0x00 or 0x01 reaches only the live wiper. Such a write changes the wiper output, leaves the stored value unchanged and starts no busy window.
- R5: Addresses 0x02 to 0x0F are general-purpose stored bytes. With bit 7 at 0 they are written and read back. With bit 7 at 1, writes to them are dropped and reads return 0x00.
- R6: The control byte is at 0x10. Bit 7 is the volatile-only mode. Bit 6 is active-low shutdown, and the output is `shutdown` = NOT bit 6. Bit 5 reads the live `nv_busy` and ignores writes. Bits 4:0 read 0.
- R7: An accepted write to the store (0x00 to 0x0F with bit 7 at 0) raises `nv_busy` on the next cycle and holds it for exactly NV_WRITE_CYCLES cycles.
- R8: While `nv_busy` is 1, writes to 0x00 to 0x10 have no effect on wipers, stored values or the control byte.
- R9: Writes to 0x11 and above have no effect, and reads of them return 0x00.
- R10: `rdata` is registered. It presents the addressed value in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, factory state of the store |
| por_recall | input | 1 | Single-cycle pulse that starts the recall of stored values |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| wiper_a | output | 8 | Live wiper code, channel A |
| wiper_b | output | 8 | Live wiper code, channel B |
| shutdown | output | 1 | High when both channels are to be disconnected |
| nv_busy | output | 1 | High while a non-volatile write is in progress |
| ready | output | 1 | High once recall is complete and accesses are served |

## Verification
The properties assume that the front end issues strobes only while `ready` is high, and that `por_recall` is a one-cycle pulse that does not coincide with an access. They also assume that each strobe lasts one cycle, with address and data held for that cycle. The stimulus drives every input on the falling clock edge, holds each strobe for exactly one cycle, and starts accesses only after it has seen `ready` high. Busy-window lockout is probed only by writes issued while `nv_busy` is already high.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int DATA_W = 8;
    localparam int CHANNELS = 2;
    localparam logic [DATA_W-1:0] FACTORY_CODE = 8'h80;

    // Control byte bit positions (read back by software, so fixed)
    localparam int CTL_VOL_BIT  = 7;
    localparam int CTL_SHDN_BIT = 6;
    localparam int CTL_BUSY_BIT = 5;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_RUN
    } dpot_state_e;
endpackage

// File: rtl/dpot_nvstore.sv
module dpot_nvstore
    import dpot_pkg::*;
#(
    parameter int NV_DEPTH = 16,
    localparam int IDX_W = $clog2(NV_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] start_a,
    output logic [DATA_W-1:0] start_b
);
    logic [DATA_W-1:0] cells [NV_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NV_DEPTH; i++) begin
                cells[i] <= (i < CHANNELS) ? FACTORY_CODE : '0;
            end
        end else if (we) begin
            cells[idx] <= din;
        end
    end

    assign dout    = cells[idx];
    assign start_a = cells[0];
    assign start_b = cells[1];
endmodule

// File: rtl/dpot_busy_timer.sv
module dpot_busy_timer #(
    parameter int CYCLES = 1000000,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            remain <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NV_DEPTH = 16,
    localparam int IDX_W = $clog2(NV_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_recall,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              nv_busy,
    input  logic [DATA_W-1:0] nv_dout,
    input  logic [DATA_W-1:0] nv_start_a,
    input  logic [DATA_W-1:0] nv_start_b,
    output logic              nv_we,
    output logic [IDX_W-1:0]  nv_idx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wiper_a,
    output logic [DATA_W-1:0] wiper_b,
    output logic              ctl_vol,
    output logic              ctl_shdn_n,
    output logic              ready
);
    dpot_state_e state, state_nx;

    logic hit_chan, hit_nv, hit_ctl, accept;
    logic wip_a_we, wip_b_we, ctl_we;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BOOT:   if (por_recall) state_nx = ST_LOAD_A;
            ST_LOAD_A: state_nx = por_recall ? ST_LOAD_A : ST_LOAD_B;
            ST_LOAD_B: state_nx = por_recall ? ST_LOAD_A : ST_RUN;
            ST_RUN:    if (por_recall) state_nx = ST_LOAD_A;
        endcase
    end

    // Outputs and access decode
    always_comb begin
        ready    = (state == ST_RUN);
        hit_chan = (addr < ADDR_W'(CHANNELS));
        hit_nv   = (addr < ADDR_W'(NV_DEPTH));
        hit_ctl  = (addr == ADDR_W'(NV_DEPTH));
        accept   = ready && wr_en && !nv_busy && !por_recall;
        nv_idx   = addr[IDX_W-1:0];
        nv_we    = accept && !ctl_vol && hit_nv;
        wip_a_we = accept && hit_chan && !addr[0];
        wip_b_we = accept && hit_chan &&  addr[0];
        ctl_we   = accept && hit_ctl;
    end

    // Wipers and control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_a    <= FACTORY_CODE;
            wiper_b    <= FACTORY_CODE;
            ctl_vol    <= 1'b0;
            ctl_shdn_n <= 1'b1;
        end else begin
            if (state == ST_LOAD_A) begin
                wiper_a    <= nv_start_a;
                ctl_vol    <= 1'b0;
                ctl_shdn_n <= 1'b1;
            end
            if (state == ST_LOAD_B) wiper_b <= nv_start_b;
            if (wip_a_we) wiper_a <= wdata;
            if (wip_b_we) wiper_b <= wdata;
            if (ctl_we) begin
                ctl_vol    <= wdata[CTL_VOL_BIT];
                ctl_shdn_n <= wdata[CTL_SHDN_BIT];
            end
        end
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (hit_chan) begin
                rdata <= ctl_vol ? (addr[0] ? wiper_b : wiper_a) : nv_dout;
            end else if (hit_nv) begin
                rdata <= ctl_vol ? '0 : nv_dout;
            end else if (hit_ctl) begin
                rdata <= '0;
                rdata[CTL_VOL_BIT]  <= ctl_vol;
                rdata[CTL_SHDN_BIT] <= ctl_shdn_n;
                rdata[CTL_BUSY_BIT] <= nv_busy;
            end else begin
                rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank
    import dpot_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NV_DEPTH = 16,
    parameter int NV_WRITE_CYCLES = 1000000,
    localparam int IDX_W = $clog2(NV_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_recall,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [7:0]        wiper_a,
    output logic [7:0]        wiper_b,
    output logic              shutdown,
    output logic              nv_busy,
    output logic              ready
);
    logic              nv_we;
    logic [IDX_W-1:0]  nv_idx;
    logic [DATA_W-1:0] nv_dout, nv_start_a, nv_start_b;
    logic              ctl_vol, ctl_shdn_n;

    dpot_nvstore #(.NV_DEPTH(NV_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (nv_we),
        .idx     (nv_idx),
        .din     (wdata),
        .dout    (nv_dout),
        .start_a (nv_start_a),
        .start_b (nv_start_b)
    );

    dpot_busy_timer #(.CYCLES(NV_WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_we),
        .busy  (nv_busy)
    );

    dpot_ctrl #(.ADDR_W(ADDR_W), .NV_DEPTH(NV_DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_recall (por_recall),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .nv_busy    (nv_busy),
        .nv_dout    (nv_dout),
        .nv_start_a (nv_start_a),
        .nv_start_b (nv_start_b),
        .nv_we      (nv_we),
        .nv_idx     (nv_idx),
        .rdata      (rdata),
        .wiper_a    (wiper_a),
        .wiper_b    (wiper_b),
        .ctl_vol    (ctl_vol),
        .ctl_shdn_n (ctl_shdn_n),
        .ready      (ready)
    );

    assign shutdown = !ctl_shdn_n;
endmodule

// File: rtl/dpot_regbank_chk.sv
module dpot_regbank_chk #(
    parameter int ADDR_W = 5,
    parameter int NV_DEPTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_recall,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        wiper_a,
    input logic [7:0]        wiper_b,
    input logic              shutdown,
    input logic              nv_busy,
    input logic              ready,
    input logic              ctl_vol
);
    a_r2_recall_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        por_recall |=> !ready);

    a_r7_busy_after_store_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !nv_busy && wr_en && !por_recall && !ctl_vol && addr < ADDR_W'(NV_DEPTH))
        |=> nv_busy);

    a_r6_shutdown_follows_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !nv_busy && wr_en && !por_recall && addr == ADDR_W'(NV_DEPTH))
        |=> (shutdown == !$past(wdata[6])));

    a_r8_busy_holds_wipers: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && nv_busy && wr_en && !por_recall)
        |=> ($stable(wiper_a) && $stable(wiper_b)));

    a_r8_busy_holds_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && nv_busy && wr_en && !por_recall)
        |=> ($stable(shutdown) && $stable(ctl_vol)));

    a_r9_high_addr_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !por_recall && addr > ADDR_W'(NV_DEPTH))
        |=> ($stable(wiper_a) && $stable(wiper_b) && $stable(shutdown) && $stable(ctl_vol)));
endmodule

bind dpot_regbank dpot_regbank_chk #(.ADDR_W(ADDR_W), .NV_DEPTH(NV_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_recall (por_recall),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .wiper_a    (wiper_a),
    .wiper_b    (wiper_b),
    .shutdown   (shutdown),
    .nv_busy    (nv_busy),
    .ready      (ready),
    .ctl_vol    (ctl_vol)
);

// File: tb/dpot_regbank_bench.sv
module dpot_regbank_bench;
    localparam int NV_CYC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_recall = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, wiper_a, wiper_b;
    logic shutdown, nv_busy, ready;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0] a;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t exp_q[$];
    logic rd_pend = 1'b0;

    always #10 clk = ~clk;

    dpot_regbank #(.NV_WRITE_CYCLES(NV_CYC)) u_dpot_regbank (
        .clk(clk), .rst_n(rst_n), .por_recall(por_recall),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wiper_a(wiper_a), .wiper_b(wiper_b),
        .shutdown(shutdown), .nv_busy(nv_busy), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver: pushes expected read data, strobes for one cycle
    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.a = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    // Monitor: compares registered read data the cycle after the strobe (R10)
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected read data", rdata, 0);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(rdata === it.exp, {"R10 ", it.tag}, rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready === 1'b0, "R1 ready low after reset", ready, 0);
        check(wiper_a === 8'h80 && wiper_b === 8'h80, "R1 wipers factory", {wiper_a, wiper_b}, 16'h8080);
        check(shutdown === 1'b0 && nv_busy === 1'b0, "R1 shutdown/busy low", {shutdown, nv_busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ready === 1'b0, "R1 ready waits for recall", ready, 0);

        // R2 recall timing
        por_recall = 1'b1;
        @(negedge clk);
        por_recall = 1'b0;
        check(ready === 1'b0, "R2 ready low during recall", ready, 0);
        @(negedge clk);
        check(ready === 1'b0, "R2 ready low in second load", ready, 0);
        @(negedge clk);
        check(ready === 1'b1, "R2 ready after recall", ready, 1);

        rd(5'h10, 8'h40, "R1 control default");
        rd(5'h00, 8'h80, "R1 stored A factory");
        rd(5'h01, 8'h80, "R1 stored B factory");

        // R3 + R7: stored write moves wiper and opens busy window
        wr(5'h00, 8'h35);
        check(wiper_a === 8'h35, "R3 stored write sets wiper A", wiper_a, 8'h35);
        n = 0;
        while (nv_busy) begin n++; @(negedge clk); end
        check(n == NV_CYC, "R7 busy window length", n, NV_CYC);

        // R8: lockout during busy
        wr(5'h01, 8'h5A);
        check(nv_busy === 1'b1, "R7 busy after stored write", nv_busy, 1);
        check(wiper_b === 8'h5A, "R3 stored write sets wiper B", wiper_b, 8'h5A);
        wr(5'h01, 8'h77);
        check(wiper_b === 8'h5A, "R8 wiper write ignored while busy", wiper_b, 8'h5A);
        wr(5'h10, 8'h00);
        check(shutdown === 1'b0, "R8 control write ignored while busy", shutdown, 0);
        rd(5'h10, 8'h60, "R6 busy bit reads 1");
        wait_idle();
        rd(5'h00, 8'h35, "R3 stored A readback");
        rd(5'h01, 8'h5A, "R8 stored B kept first value");

        // R5 general purpose bytes, range ends
        wr(5'h02, 8'hA5); wait_idle();
        wr(5'h0F, 8'h3C); wait_idle();
        rd(5'h02, 8'hA5, "R5 gp 0x02 readback");
        rd(5'h0F, 8'h3C, "R5 gp 0x0F readback");

        // R6 control write: bit 5 and low bits ignored
        wr(5'h10, 8'hFF);
        check(nv_busy === 1'b0, "R6 control write starts no busy", nv_busy, 0);
        check(shutdown === 1'b0, "R6 shdn bit 1 keeps running", shutdown, 0);
        rd(5'h10, 8'hC0, "R6 control readback");

        // R4 volatile-only mode
        wr(5'h00, 8'h11);
        check(wiper_a === 8'h11, "R4 volatile write sets wiper", wiper_a, 8'h11);
        check(nv_busy === 1'b0, "R4 volatile write no busy", nv_busy, 0);
        rd(5'h00, 8'h11, "R4 read reaches wiper");
        wr(5'h02, 8'h22);
        check(nv_busy === 1'b0, "R5 gp write dropped in volatile mode", nv_busy, 0);
        rd(5'h02, 8'h00, "R5 gp reads zero in volatile mode");

        // R6 shutdown asserted
        wr(5'h10, 8'h80);
        check(shutdown === 1'b1, "R6 shdn bit 0 shuts down", shutdown, 1);

        // R9 high addresses
        wr(5'h11, 8'h99);
        wr(5'h1F, 8'h00);
        check(wiper_a === 8'h11 && wiper_b === 8'h5A, "R9 high write no wiper effect", {wiper_a, wiper_b}, 16'h115A);
        check(shutdown === 1'b1, "R9 high write no control effect", shutdown, 1);
        rd(5'h11, 8'h00, "R9 read 0x11");
        rd(5'h1F, 8'h00, "R9 read 0x1F");

        // back to stored mode; volatile writes left stores alone
        wr(5'h10, 8'h40);
        check(shutdown === 1'b0, "R6 shutdown released", shutdown, 0);
        rd(5'h00, 8'h35, "R4 stored A untouched");
        rd(5'h02, 8'hA5, "R5 gp untouched by dropped write");

        // R2 recall restores stored values
        wr(5'h10, 8'h80);
        por_recall = 1'b1;
        @(negedge clk);
        por_recall = 1'b0;
        repeat (2) @(negedge clk);
        check(ready === 1'b1, "R2 ready after second recall", ready, 1);
        check(wiper_a === 8'h35, "R2 recall wiper A", wiper_a, 8'h35);
        check(wiper_b === 8'h5A, "R2 recall wiper B", wiper_b, 8'h5A);
        check(shutdown === 1'b0, "R2 recall resets control", shutdown, 0);
        rd(5'h10, 8'h40, "R2 control after recall");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule